// File: doc/BRIEF.md
# One-Bit Branching Program Sequencer

This block is a tiny controller that has no opcode. It runs one instruction over and over, and every instruction does two things. It writes one bit to an addressable output latch, and it tests one input, which picks one of two successor entries. The program lives in a byte-wide store organised as 256 entries of four bytes each. A write port lets the store be filled from outside. There is no data memory. State is held either by the branch taken or by an output that is wired back to an input.

An instruction takes two clock cycles. In the first cycle (the I/O phase) the sequencer fetches an I/O byte and copies the selected synchronized input into a one-bit flag. In the second cycle (the jump phase) it fetches a jump byte, using the newly updated flag to choose it. The output write from the I/O byte reaches its latch at the edge that ends the jump phase. At that same edge the jump byte becomes the current entry. The store address is the entry number, followed by the phase bit, followed by the flag bit. Output address 7 has no storage behind it. Programs use it as the write target when no output is wanted.

Top module: `obs_sequencer`

## Requirements
- R1: The program store is written through `prog_we`/`prog_addr`/`prog_wdata`. Address bits 9:2 select the entry and bits 1:0 select the byte within that entry.
- R2: The phases strictly alternate, starting with the I/O phase. The I/O phase reads offset {0,flag} of the current entry. The jump phase reads offset {1,flag}.
- R3: I/O byte layout:
  - bit 0 is the output data;
  - bits 3:1 are the output latch address;
  - bits 6:4 are the input select;
  - bit 7 is ignored.
- R4: At the end of the I/O phase, the flag takes the synchronized input named by the input select. Flag value 1 selects offsets 01 and 11, and flag value 0 selects offsets 00 and 10.
- R5: The jump phase uses the flag value written at the end of the I/O phase of the same instruction.
- R6: The output write lands on the clock edge that ends the jump phase, one stage after the I/O byte was fetched. At most one latch bit changes per edge, and the latches never change at the edge that ends the I/O phase.
- R7: The fetched jump byte becomes the entry number used from the next I/O phase on. The entry does not change at the edge that ends the I/O phase.
- R8: A write to output address 7 leaves all of `latch_o` unchanged.
- R9: While `rst_n` is low:
  - all latches and the flag read 0, and this is asynchronous;
  - nothing is executed.
  After `rst_n` rises, execution starts in the I/O phase at entry 0, offset 00.
- R10: The inputs pass through a two-flop synchronizer before the input select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | External inputs, synchronized inside |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 10 | Program store write address {entry, offset} |
| prog_wdata | input | 8 | Program store write data |
| latch_o | output | 7 | Addressable output latches 0 to 6 |

## Verification
A mirror program copies each of inputs 0 to 6 to the output latch of the same number. It does this only through branches, because the block holds no data. The program is run with all-zero, all-one, alternating, single-bit and block patterns, plus patterns that toggle input 7, which is never selected. These patterns separate the cases of a swapped or shifted latch or input address, an inverted flag-to-offset choice, a stuck latch, and a latch that cannot be cleared back to 0.

A second, directed program makes the first instruction's two I/O bytes and two jump bytes target different latches. This shows which offset was fetched and in which cycle the write became visible. Reset is tried both from power-up and in the middle of a run.

// File: rtl/obs_pkg.sv
`timescale 1ns/1ps
package obs_pkg;

   typedef enum logic {
      PH_IO   = 1'b0,
      PH_JUMP = 1'b1
   } phase_e;

   // number of latch bits that own storage for a given select width
   function automatic int latch_count(input int sel_w, input bit discard_top);
      return (1 << sel_w) - (discard_top ? 1 : 0);
   endfunction

endpackage

// File: rtl/obs_progmem.sv
`timescale 1ns/1ps
module obs_progmem #(
   parameter int ADDR_W = 10,
   parameter int WORD_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);

   generate
      if (ADDR_W < 3 || ADDR_W > 14) begin : g_bad_depth
         $error("obs_progmem: ADDR_W out of range");
      end
      if (WORD_W < 1) begin : g_bad_width
         $error("obs_progmem: WORD_W must be positive");
      end
   endgenerate

   logic [WORD_W-1:0] store_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         store_q[waddr] <= wdata;
      end
   end

   assign rdata = store_q[raddr];

endmodule

// File: rtl/obs_insync.sv
`timescale 1ns/1ps
module obs_insync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("obs_insync: STAGES must lie in 0..4");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] chain_q [STAGES];
         always_ff @(posedge clk) begin
            chain_q[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
               chain_q[k] <= chain_q[k-1];
            end
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/obs_outlatch.sv
`timescale 1ns/1ps
module obs_outlatch #(
   parameter int SEL_W       = 3,
   parameter bit DISCARD_TOP = 1'b1,
   localparam int N_Q        = obs_pkg::latch_count(SEL_W, DISCARD_TOP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SEL_W-1:0] sel,
   input  logic             d,
   output logic [N_Q-1:0]   q
);

   generate
      if (N_Q < 1) begin : g_bad_count
         $error("obs_outlatch: no latch bits left");
      end

      // with DISCARD_TOP the highest address matches no bit below
      for (genvar i = 0; i < N_Q; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else if (we && (sel == SEL_W'(i))) begin
               bit_q <= d;
            end
         end
         assign q[i] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/obs_sequencer.sv
`timescale 1ns/1ps
module obs_sequencer #(
   parameter int ENTRY_W     = 8,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit DISCARD_TOP = 1'b1,
   localparam int ADDR_W     = ENTRY_W + 2,
   localparam int WORD_W     = ENTRY_W,
   localparam int N_IN       = 1 << SEL_W,
   localparam int N_LATCH    = obs_pkg::latch_count(SEL_W, DISCARD_TOP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_IN-1:0]    pin_i,
   input  logic               prog_we,
   input  logic [ADDR_W-1:0]  prog_addr,
   input  logic [WORD_W-1:0]  prog_wdata,
   output logic [N_LATCH-1:0] latch_o
);
   import obs_pkg::*;

   localparam int DATA_BIT = 0;
   localparam int OSEL_LO  = 1;
   localparam int OSEL_HI  = SEL_W;
   localparam int ISEL_LO  = SEL_W + 1;
   localparam int ISEL_HI  = 2 * SEL_W;

   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("obs_sequencer: SEL_W must lie in 1..4");
      end
      if (WORD_W < 2 * SEL_W + 1) begin : g_bad_fmt
         $error("obs_sequencer: jump byte too narrow for the I/O fields");
      end
   endgenerate

   phase_e            ph_q;
   logic              flag_q;
   logic [ENTRY_W-1:0] entry_q;
   logic [SEL_W:0]    io_q;        // output fields of the I/O byte, one stage on
   logic [ADDR_W-1:0] fetch_addr;
   logic [WORD_W-1:0] mem_rdata;
   logic [WORD_W-1:0] fetch_w;
   logic [N_IN-1:0]   pin_s;
   logic [SEL_W-1:0]  in_sel;
   logic              sampled;
   logic              latch_we;

   obs_insync #(
      .W      (N_IN),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk (clk),
      .d   (pin_i),
      .q   (pin_s)
   );

   assign fetch_addr = {entry_q, logic'(ph_q), flag_q};

   obs_progmem #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W)
   ) u_mem (
      .clk   (clk),
      .we    (prog_we),
      .waddr (prog_addr),
      .wdata (prog_wdata),
      .raddr (fetch_addr),
      .rdata (mem_rdata)
   );

   // shadow region under reset: every byte reads as "jump to entry 0"
   assign fetch_w = rst_n ? mem_rdata : '0;
   assign in_sel  = fetch_w[ISEL_HI:ISEL_LO];
   assign sampled = pin_s[in_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IO;
         flag_q  <= 1'b0;
         entry_q <= '0;
         io_q    <= '0;
      end else begin
         unique case (ph_q)
            PH_IO: begin
               flag_q <= sampled;
               io_q   <= fetch_w[SEL_W:0];
               ph_q   <= PH_JUMP;
            end
            PH_JUMP: begin
               entry_q <= fetch_w;
               ph_q    <= PH_IO;
            end
            default: ph_q <= PH_IO;
         endcase
      end
   end

   assign latch_we = (ph_q == PH_JUMP);

   obs_outlatch #(
      .SEL_W       (SEL_W),
      .DISCARD_TOP (DISCARD_TOP)
   ) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (latch_we),
      .sel   (io_q[OSEL_HI:OSEL_LO]),
      .d     (io_q[DATA_BIT]),
      .q     (latch_o)
   );

endmodule

// File: rtl/obs_sequencer_chk.sv
`timescale 1ns/1ps
module obs_sequencer_chk #(
   parameter int ENTRY_W = 8,
   parameter int SEL_W   = 3,
   parameter int N_LATCH = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               phase_q,
   input logic               flag_q,
   input logic [ENTRY_W-1:0] entry_q,
   input logic               wr_en,
   input logic [SEL_W-1:0]   wr_sel,
   input logic [N_LATCH-1:0] latch_o
);

   localparam logic [SEL_W-1:0] SEL_DISCARD = '1;

   // R2: phases alternate
   assert_io_then_jump_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == 1'b0) |=> (phase_q == 1'b1));
   assert_jump_then_io_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == 1'b1) |=> (phase_q == 1'b0));

   // R5: flag held across the jump-phase edge
   assert_flag_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == 1'b1) |=> $stable(flag_q));

   // R6: latches quiet at the edge that ends the I/O phase
   assert_no_write_in_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == 1'b0) |=> $stable(latch_o));

   // R6: never more than one latch bit changes per edge
   assert_single_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(latch_o ^ $past(latch_o)) <= 1);

   // R7: entry only moves at the end of the jump phase
   assert_entry_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == 1'b0) |=> $stable(entry_q));

   // R8: write to the discard address changes no latch
   assert_discard_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_DISCARD) |=> $stable(latch_o));

   // R9: reset holds latches and flag at zero
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R9: assert (latch_o == '0 && flag_q == 1'b0);
      end
   end

endmodule

bind obs_sequencer obs_sequencer_chk #(
   .ENTRY_W (ENTRY_W),
   .SEL_W   (SEL_W),
   .N_LATCH (N_LATCH)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .phase_q (logic'(ph_q)),
   .flag_q  (flag_q),
   .entry_q (entry_q),
   .wr_en   (latch_we),
   .wr_sel  (io_q[SEL_W:1]),
   .latch_o (latch_o)
);

// File: tb/obs_sequencer_tb.sv
`timescale 1ns/1ps
module obs_sequencer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pin_i = '0;
   logic       prog_we = 1'b0;
   logic [9:0] prog_addr = '0;
   logic [7:0] prog_wdata = '0;
   logic [6:0] latch_o;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   obs_sequencer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (pin_i),
      .prog_we    (prog_we),
      .prog_addr  (prog_addr),
      .prog_wdata (prog_wdata),
      .latch_o    (latch_o)
   );

   // input patterns for the mirror program; expected latches = pattern[6:0]
   localparam logic [7:0] PAT [10] = '{
      8'h00, 8'h7F, 8'h55, 8'h2A, 8'hC1,
      8'h40, 8'h3C, 8'h80, 8'h01, 8'h00
   };

   task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic poke(input int entry, input int ofs, input logic [7:0] val);
      @(negedge clk);
      prog_we    = 1'b1;
      prog_addr  = 10'((entry << 2) | ofs);
      prog_wdata = val;
      @(negedge clk);
      prog_we    = 1'b0;
   endtask

   // I/O byte per R3: {spare, in_sel[2:0], out_sel[2:0], data}
   function automatic logic [7:0] iob(input int in_sel, input int out_sel, input bit d);
      return 8'((in_sel << 4) | (out_sel << 1) | int'(d));
   endfunction

   task automatic put_entry(input int e, input logic [7:0] io0, input logic [7:0] io1,
                            input logic [7:0] j0, input logic [7:0] j1);
      poke(e, 0, io0);
      poke(e, 1, io1);
      poke(e, 2, j0);
      poke(e, 3, j1);
   endtask

   // mirror: entry i tests input i; 16+i sets latch i, 32+i clears it
   task automatic load_mirror();
      for (int i = 0; i < 7; i++) begin
         put_entry(i, iob(i, 7, 1'b0), iob(i, 7, 1'b0), 8'(32 + i), 8'(16 + i));
         put_entry(16 + i, iob(0, i, 1'b1), iob(0, i, 1'b1), 8'(i + 1), 8'(i + 1));
         put_entry(32 + i, iob(0, i, 1'b0), iob(0, i, 1'b0), 8'(i + 1), 8'(i + 1));
      end
      put_entry(7, iob(0, 7, 1'b0), iob(0, 7, 1'b0), 8'd0, 8'd0);
   endtask

   // directed program: offsets of entry 0 write different latches
   task automatic load_directed();
      put_entry(0, iob(0, 1, 1'b1), iob(0, 2, 1'b1), 8'd3, 8'd5);
      put_entry(3, iob(0, 6, 1'b1), iob(0, 6, 1'b1), 8'd3, 8'd3);
      // offset 01 carries a set spare bit 7 (R3)
      put_entry(5, iob(1, 3, 1'b1), 8'h80 | iob(1, 4, 1'b1), 8'd6, 8'd9);
      put_entry(6, iob(1, 7, 1'b1), iob(1, 5, 1'b1), 8'd6, 8'd6);
      put_entry(9, iob(0, 6, 1'b1), iob(0, 6, 1'b1), 8'd9, 8'd9);
   endtask

   task automatic run_directed_start(input string pass);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check({"R6 no write at I/O edge ", pass}, latch_o, 7'h00);
      @(posedge clk); #1;
      check({"R2 R9 first fetch entry0 offset00 ", pass}, latch_o, 7'h02);
      @(posedge clk); #1;
      check({"R6 quiet during I/O phase ", pass}, latch_o, 7'h02);
      @(posedge clk); #1;
      check({"R4 R5 R7 flag1 branch to offset01 ", pass}, latch_o, 7'h12);
   endtask

   initial begin
      rst_n = 1'b0;
      load_mirror();
      repeat (4) @(posedge clk);
      #1;
      check("R9 reset state", latch_o, 7'h00);

      // vector walk: mirror program copies inputs 0..6 to latches (R1 R3 R4 R10)
      @(negedge clk);
      rst_n = 1'b1;
      for (int v = 0; v < 10; v++) begin
         @(negedge clk);
         pin_i = PAT[v];
         repeat (100) @(posedge clk);
         #1;
         check($sformatf("R1 R3 R4 R10 mirror pattern %02h", PAT[v]), latch_o, PAT[v][6:0]);
      end

      // mid-run asynchronous reset (R9)
      @(negedge clk);
      pin_i = 8'h7F;
      repeat (100) @(posedge clk);
      #2;
      rst_n = 1'b0;
      #1;
      check("R9 async clear mid-run", latch_o, 7'h00);

      // directed program loaded while held in reset
      load_directed();
      pin_i = 8'h01;   // input 0 high, input 1 low
      repeat (6) @(posedge clk);
      #1;
      check("R9 nothing executes while held", latch_o, 7'h00);
      run_directed_start("first");

      repeat (40) @(posedge clk);
      #1;
      check("R8 discard writes leave latches", latch_o, 7'h12);

      // reset again mid-run and repeat the start sequence
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R9 async clear directed", latch_o, 7'h00);
      repeat (3) @(posedge clk);
      run_directed_start("second");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule